// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a NOR flash and waits for a program, an erase or an erase suspend to finish. A one-cycle `start` captures the operation kind, the polling method, the address to poll and the data that was programmed. The block then reads the status word at that address through a single-beat read port, again and again, until the status shows that the embedded operation is over.

Two polling methods are available. The bit-7 method compares bit 7 of one status read against the value that is expected once the operation is over. The toggle method reads twice in a row and compares bit 6 of the two words. While bit 6 keeps flipping, the device is still working. The poll address has to be valid for the operation: the word being programmed, or any word inside the block being erased.

When the operation finishes, `done` pulses for one cycle, and `suspended` pulses with it if the wait was for an erase suspend. If a parameterised number of poll iterations passes without completion, the wait ends with a `timeout` pulse instead.

The read port is a request/response pair. A request is a valid/ready handshake: `rd_valid` stays high and `rd_addr` stays constant until a cycle in which `rd_ready` is high, and that cycle transfers the request. Only one request is outstanding at a time. Its response arrives as a single-cycle `rsp_valid` beat and cannot be back-pressured. The block never raises a new request before the previous response has arrived.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `busy`, `done`, `suspended`, `timeout` and `rd_valid` are all low.
- R2: `busy` is high from the first edge that samples `start` while idle. `rd_valid` is high from the second such edge, with `rd_addr` equal to the `poll_addr` that was captured with `start`.
- R3: Once raised, `rd_valid` stays high with a stable `rd_addr` until a `rd_ready` cycle. Every request carries the captured address.
- R4: With the bit-7 method (`use_toggle`=0) and `op`=0 (program), one read makes one iteration. The operation is complete when bit 7 of the status equals bit 7 of `exp_data`.
- R5: With the bit-7 method and `op`=1 (erase), the operation is complete when status bit 7 reads 1. `op`=3 behaves like `op`=1.
- R6: With the toggle method (`use_toggle`=1), each iteration makes two reads. The operation is complete when bit 6 of the two words is equal. Other bits are ignored.
- R7: With `op`=2 (waiting for an erase suspend), completion uses the erase rule for the chosen method, and `suspended` pulses together with `done`. For every other op, `suspended` stays low.
- R8: `done` and `timeout` are single-cycle pulses, never high together. The block is idle in the cycle after either one, and no further reads are made.
- R9: A `start` while `busy` is ignored. The ongoing wait keeps its address, op and method.
- R10: If iteration number `MAX_POLLS` is still not complete, `timeout` pulses instead of `done`. That makes exactly `MAX_POLLS` reads with the bit-7 method, or 2·`MAX_POLLS` reads with the toggle method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a wait (taken only when idle) |
| op | input | 2 | 0 program, 1 erase, 2 erase-suspend wait, 3 as erase |
| use_toggle | input | 1 | 0 bit-7 method, 1 toggle method |
| poll_addr | input | ADDR_W | Address polled for status |
| exp_data | input | DATA_W | Data being programmed (bit 7 used) |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read request address |
| rsp_valid | input | 1 | Read data beat |
| rsp_data | input | DATA_W | Status word read |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | Pulse: operation finished |
| suspended | output | 1 | Pulse with `done` when waiting for a suspend |
| timeout | output | 1 | Pulse: poll limit reached |

## Verification
Timing is counted in rising edges. After the edge that samples `start`, `busy` is due at once and the first `rd_valid` is due one edge later. After the edge that samples the last needed `rsp_valid`, one edge makes the decision, and the outcome pulse appears on the next edge for exactly one cycle.

The bench drives and samples on falling edges. It checks `busy` and the first request at the two falling edges after `start`. It then scans every falling edge, within a bound, for the outcome pulse, and checks the following falling edge for idle.

A reference model answers the reads with status words computed from a chosen busy-read count. The bench works out the expected outcome and read count arithmetically and compares them with what it sees. It sweeps method, op, expected bit, busy length, response latency and request stalls.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ1, ST_READ2, ST_CHECK, ST_DONE
  } fdp_state_e;

  localparam logic [1:0] OP_PROGRAM = 2'd0;
  localparam logic [1:0] OP_ERASE   = 2'd1;
  localparam logic [1:0] OP_SUSPEND = 2'd2;
endpackage

// File: rtl/fdp_rd_port.sv
module fdp_rd_port (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic rd_valid,
  input  logic rd_ready,
  input  logic rsp_valid,
  output logic idle,
  output logic fin
);
  typedef enum logic [1:0] {P_IDLE, P_REQ, P_WAIT} port_e;
  port_e ps;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps <= P_IDLE;
    end else begin
      unique case (ps)
        P_IDLE: if (go) ps <= P_REQ;
        P_REQ:  if (rd_ready) ps <= P_WAIT;
        P_WAIT: if (rsp_valid) ps <= P_IDLE;
        default: ps <= P_IDLE;
      endcase
    end
  end

  assign rd_valid = (ps == P_REQ);
  assign idle     = (ps == P_IDLE);
  assign fin      = (ps == P_WAIT) && rsp_valid;
endmodule

// File: rtl/fdp_judge.sv
module fdp_judge #(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              use_toggle,
  input  logic [1:0]        op,
  input  logic              exp_bit,
  input  logic [DATA_W-1:0] first,
  input  logic [DATA_W-1:0] second,
  output logic              finished
);
  import fdp_pkg::*;

  always_comb begin
    if (use_toggle)
      finished = (first[TOG_BIT] == second[TOG_BIT]);
    else if (op == OP_PROGRAM)
      finished = (first[POLL_BIT] == exp_bit);
    else
      finished = first[POLL_BIT];
  end
endmodule

// File: rtl/fdp_iter_cnt.sv
module fdp_iter_cnt #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (step)       cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_IDX);
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 4096,
  parameter int POLL_BIT  = 7,
  parameter int TOG_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              use_toggle,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic [DATA_W-1:0] exp_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              done,
  output logic              suspended,
  output logic              timeout
);
  import fdp_pkg::*;

  fdp_state_e        state;
  logic [1:0]        op_q;
  logic              tog_q;
  logic              expb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] d1_q, d2_q;
  logic              to_q;

  logic start_ok, go, port_idle, fin, finished, last;
  logic in_read, check_busy;

  assign start_ok   = start && (state == ST_IDLE);
  assign in_read    = (state == ST_READ1) || (state == ST_READ2);
  assign go         = in_read && port_idle;
  assign check_busy = (state == ST_CHECK) && !finished;

  fdp_rd_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rsp_valid(rsp_valid),
    .idle     (port_idle),
    .fin      (fin)
  );

  fdp_judge #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_judge (
    .use_toggle(tog_q),
    .op        (op_q),
    .exp_bit   (expb_q),
    .first     (d1_q),
    .second    (d2_q),
    .finished  (finished)
  );

  fdp_iter_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(start_ok),
    .step (check_busy && !last),
    .last (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= '0;
      tog_q  <= 1'b0;
      expb_q <= 1'b0;
      addr_q <= '0;
      d1_q   <= '0;
      d2_q   <= '0;
      to_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_ok) begin
          op_q   <= op;
          tog_q  <= use_toggle;
          expb_q <= exp_data[POLL_BIT];
          addr_q <= poll_addr;
          to_q   <= 1'b0;
          state  <= ST_READ1;
        end
        ST_READ1: if (fin) begin
          d1_q  <= rsp_data;
          state <= tog_q ? ST_READ2 : ST_CHECK;
        end
        ST_READ2: if (fin) begin
          d2_q  <= rsp_data;
          state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (finished) begin
            state <= ST_DONE;
          end else if (last) begin
            to_q  <= 1'b1;
            state <= ST_DONE;
          end else begin
            state <= ST_READ1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr   = addr_q;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE) && !to_q;
  assign timeout   = (state == ST_DONE) && to_q;
  assign suspended = done && (op_q == OP_SUSPEND);
endmodule

// File: rtl/fdp_chk.sv
module fdp_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              done,
  input logic              suspended,
  input logic              timeout
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid && !done && !timeout); // R1
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R3
  AST_SUSP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> done); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done || timeout |=> !done && !timeout && !busy); // R8
  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout)); // R10
endmodule

bind flash_done_poller fdp_chk #(.ADDR_W(ADDR_W)) u_fdp_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .done(done), .suspended(suspended), .timeout(timeout)
);

// File: tb/test_flash_done_poller.sv
`timescale 1ns/1ps
module test_flash_done_poller;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int MAXP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic use_toggle = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic [DW-1:0] exp_data = '0;
  logic rd_valid, rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic busy, done, suspended, timeout;

  always #4 clk = ~clk;

  flash_done_poller #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAXP)) i_flash_done_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .use_toggle(use_toggle),
    .poll_addr(poll_addr), .exp_data(exp_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .busy(busy), .done(done), .suspended(suspended),
    .timeout(timeout)
  );

  int checks = 0;
  int fails = 0;
  // model state for the current test
  int t_n = 0;
  logic t_tog = 1'b0;
  logic [1:0] t_op = 2'd0;
  logic t_exp = 1'b0;
  logic [AW-1:0] t_addr = '0;
  int t_lat = 0;
  logic t_stall = 1'b0;
  int reads = 0;
  int addr_bad = 0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic tog6(input int k);
    if (k < t_n) return k[0];
    return t_n[0];
  endfunction

  function automatic logic [DW-1:0] stat(input int k);
    logic [DW-1:0] v;
    v = DW'(k * 755) ^ 16'hA5C3;
    if (t_tog) begin
      v[6] = tog6(k);
    end else begin
      v[6] = k[0];
      if (t_op == 2'd0) v[7] = (k >= t_n) ? t_exp : ~t_exp;
      else              v[7] = (k >= t_n);
    end
    return v;
  endfunction

  // read responder: monitors handshakes at rising edges, answers at falling edges
  initial begin
    logic hs, pend, ph;
    int lat, idx, cur;
    hs = 0; pend = 0; ph = 0; lat = 0; idx = 0; cur = 0;
    forever begin
      @(posedge clk);
      if (rd_valid && rd_ready) begin
        hs = 1; idx = reads; reads++;
        if (rd_addr != t_addr) addr_bad++;
      end
      @(negedge clk);
      ph = ~ph;
      rd_ready = t_stall ? ph : 1'b1;
      rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          rsp_valid = 1'b1; rsp_data = stat(cur); pend = 0;
        end else lat--;
      end
      if (hs) begin hs = 0; pend = 1; lat = t_lat; cur = idx; end
    end
  end

  task automatic run(input logic tog, input logic [1:0] o, input logic e, input int n,
                     input int lat, input logic stall, input logic restart, input string req);
    int exp_reads, found, seen_out, got_done, got_to, got_susp;
    logic exp_done;
    t_tog = tog; t_op = o; t_exp = e; t_n = n; t_lat = lat; t_stall = stall;
    t_addr = AW'(n * 97 + o * 13 + 5);
    @(negedge clk);
    reads = 0; addr_bad = 0;
    poll_addr = t_addr; op = o; use_toggle = tog;
    exp_data = DW'(16'h3C5A ^ (n * 11));
    exp_data[7] = e;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    @(negedge clk);
    check(rd_valid === 1'b1 && rd_addr === t_addr, "R2 first request", int'(rd_addr), int'(t_addr));
    if (restart) begin
      // R9: a second start mid-wait with other parameters must be ignored
      poll_addr = ~t_addr; op = 2'd1; use_toggle = ~tog; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    seen_out = 0; got_done = 0; got_to = 0; got_susp = 0;
    for (int c = 0; c < 3000 && !seen_out; c++) begin
      @(negedge clk);
      if (done || timeout) begin
        seen_out = 1; got_done = int'(done); got_to = int'(timeout); got_susp = int'(suspended);
      end
    end
    check(seen_out == 1, "R8 outcome pulse (wait bound)", seen_out, 1);
    if (tog) begin
      found = -1;
      for (int i = 0; i < MAXP && found < 0; i++)
        if (tog6(2 * i) == tog6(2 * i + 1)) found = i;
      exp_done = (found >= 0);
      exp_reads = exp_done ? 2 * (found + 1) : 2 * MAXP;
    end else begin
      exp_done = (n < MAXP);
      exp_reads = exp_done ? n + 1 : MAXP;
    end
    check(got_done == int'(exp_done) && got_to == int'(!exp_done),
          exp_done ? req : "R10 timeout", got_done * 2 + got_to, exp_done ? 2 : 1);
    check(got_susp == int'(exp_done && o == 2'd2), "R7 suspended flag", got_susp,
          int'(exp_done && o == 2'd2));
    @(negedge clk);
    check(!done && !timeout && !busy, "R8 single pulse then idle", int'(busy), 0);
    repeat (3) @(negedge clk);
    check(reads == exp_reads, restart ? "R9 read count" : req, reads, exp_reads);
    check(addr_bad == 0, "R3 request address", addr_bad, 0);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !suspended && !timeout && !rd_valid, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !rd_valid, "R1 idle after reset", int'(rd_valid), 0);
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 3; o++)
        for (int e = 0; e < 2; e++)
          for (int n = 0; n <= MAXP + 1; n++)
            run(m[0], o[1:0], e[0], n, n % 3, 1'((n + o) % 2), 1'b0,
                m == 1 ? "R6 toggle completion" : (o == 0 ? "R4 program bit7" :
                (o == 1 ? "R5 erase bit7" : "R7 suspend bit7")));
    run(1'b0, 2'd3, 1'b0, 2, 1, 1'b0, 1'b0, "R5 op3 as erase");
    run(1'b0, 2'd0, 1'b1, 3, 2, 1'b1, 1'b1, "R9 start while busy");
    run(1'b1, 2'd0, 1'b0, 4, 0, 1'b0, 1'b1, "R9 start while busy toggle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule